// File: doc/BRIEF.md
# Fuse Shadow Cache Loader

This block keeps a packed set of read-only shadow registers in step with a one-time-programmable fuse array. The shadow words are gathered from fuse rows spread across the array. A sequencer walks a fixed list of 42 rows. For each row it issues one read on the array's row port, takes the returned word one cycle later, applies the mask that belongs to that shadow word, and writes the result into the shadow store. When the last row has been written, a cache-done bit is raised in the status byte.

A load begins on its own once reset is released. A new load begins when software writes the cache-load register with bit 0 set. A request that arrives while a load is running does not cut the current row short: that row finishes, and then the walk starts again from the first row. The status byte also carries three array test-bit check results straight from an input, registered once. Software reads shadow words by index through a registered read port. Words not yet loaded since reset read as zero, and so do indices past the end of the map.

Top module: `fuse_shadow_loader`

## Requirements
- R1: In reset and until each shadow word has been loaded, a read of that word returns 0. Status bit 5 (cache done) is 0 out of reset.
- R2: After reset the block reads exactly 42 fuse rows, one per read strobe, and then sets status bit 5. Each read row is one of 3–6, 8–17, 20–23 or 40–63.
- R3: Shadow index 0 holds fuse row 22 with every bit in its own position.
- R4: Shadow index 1 holds fuse row 16 ANDed with 0x0001FFFF.
- R5: Shadow indices 2 and 3 hold rows 20 and 21. Indices 4, 5 and 6 hold rows 3, 4 and 5. Index 7 holds row 17 and index 8 holds row 6.
- R6: Shadow indices 9–16 hold rows 8–15. Index 17 holds row 23. Indices 18–29 hold rows 40–51 and indices 30–41 hold rows 52–63.
- R7: A cache-load write with bit 0 = 1 starts a new load, and status bit 5 reads 0 on the cycle after the write. A cache-load write with bit 0 = 0 starts no row reads and leaves status bit 5 unchanged.
- R8: A load request made during a load lets the current row finish, then restarts from the first row. Status bit 5 stays 0 until that restarted walk has copied every row.
- R9: Status bits 2:0 equal the test-bit check input as it was one clock earlier. Status bits 3, 4, 6 and 7 read 0.
- R10: Shadow read data appears one clock after the index is presented. Any index of 42 or above reads 0.
- R11: A fuse read strobe is never high on two cycles in a row, and every shadow write comes on the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl_we | input | 1 | Write strobe for the cache-load register |
| cl_wdata | input | 32 | Cache-load write data; bit 0 requests a load |
| fuse_rd_en | output | 1 | Fuse row read strobe |
| fuse_rd_row | output | 6 | Fuse row being read |
| fuse_rd_data | input | 32 | Fuse row word, valid one cycle after the strobe |
| tbit_chk | input | 3 | Array test-bit check results |
| sh_rd_idx | input | 6 | Shadow word index to read |
| sh_rd_data | output | 32 | Shadow word, one cycle after the index |
| status | output | 8 | Bits 2:0 test-bit results, bit 5 cache done |

## Verification
The assertions assume that the fuse array returns its row word exactly one cycle after the strobe, and that load requests are single-cycle writes. The bench's fuse model is a registered row array that answers every strobe on the next edge. Requests are driven as one-cycle pulses on the falling edge. Fuse contents change only at moments a correct design tolerates: while idle, or together with a restart request, so that any word kept from before the restart shows up as a mismatch.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ROW_AW     = 6;
  localparam int unsigned N_SHADOW   = 42;
  localparam int unsigned STEP_W     = $clog2(N_SHADOW);
  localparam int unsigned UCTRL_KEEP = 17;
  localparam int unsigned IDX_UCTRL  = 1;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ISSUE   = 2'd1,
    ST_CAPTURE = 2'd2
  } seq_state_e;

  // Shadow index -> fuse row. Shadow index equals the step number.
  function automatic logic [ROW_AW-1:0] step_row(input logic [STEP_W-1:0] k);
    int unsigned kk;
    int unsigned r;
    kk = 32'(k);
    if (kk == 0)       r = 22;
    else if (kk == 1)  r = 16;
    else if (kk == 2)  r = 20;
    else if (kk == 3)  r = 21;
    else if (kk < 7)   r = kk - 1;
    else if (kk == 7)  r = 17;
    else if (kk == 8)  r = 6;
    else if (kk < 17)  r = kk - 1;
    else if (kk == 17) r = 23;
    else               r = kk + 22;
    return ROW_AW'(r);
  endfunction

  // Per-word mask; only the user control word is trimmed.
  function automatic logic [WORD_W-1:0] step_mask(input logic [STEP_W-1:0] k);
    logic [WORD_W-1:0] m;
    m = '1;
    if (32'(k) == IDX_UCTRL) m = {WORD_W{1'b1}} >> (WORD_W - UCTRL_KEEP);
    return m;
  endfunction

endpackage

// File: rtl/fsl_sequencer.sv
module fsl_sequencer
  import fsl_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  output logic              fuse_rd_en,
  output logic [ROW_AW-1:0] fuse_rd_row,
  input  logic [DW-1:0]     fuse_rd_data,
  output logic              wr_en,
  output logic [STEP_W-1:0] wr_idx,
  output logic [DW-1:0]     wr_data,
  output logic              load_start,
  output logic              load_finish
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_SHADOW - 1);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic              pend;
  logic              boot_q;
  logic              capture;
  logic              restart;

  assign capture     = (state == ST_CAPTURE);
  assign restart     = capture && (pend || load_req);
  assign load_start  = (state == ST_IDLE) && (load_req || boot_q);
  assign load_finish = capture && !restart && (step == LAST);

  assign fuse_rd_en  = (state == ST_ISSUE);
  assign fuse_rd_row = step_row(step);

  assign wr_en   = capture;
  assign wr_idx  = step;
  assign wr_data = fuse_rd_data & DW'(step_mask(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      step   <= '0;
      pend   <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load_start) begin
            state  <= ST_ISSUE;
            step   <= '0;
            boot_q <= 1'b0;
          end
        end
        ST_ISSUE: begin
          if (load_req) pend <= 1'b1;
          state <= ST_CAPTURE;
        end
        ST_CAPTURE: begin
          if (restart) begin
            step  <= '0;
            pend  <= 1'b0;
            state <= ST_ISSUE;
          end else if (step == LAST) begin
            state <= ST_IDLE;
          end else begin
            step  <= step + STEP_W'(1);
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: one row in flight at a time
  a_r11_one_row: assert property (@(posedge clk) disable iff (rst)
    fuse_rd_en |=> !fuse_rd_en);

  // R11: every shadow write is the answer to the previous strobe
  a_r11_write_after_read: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(fuse_rd_en));

  // R2: only rows that belong to the map are ever read
  a_r2_row_in_map: assert property (@(posedge clk) disable iff (rst)
    fuse_rd_en |-> (fuse_rd_row inside {[6'd3:6'd6], [6'd8:6'd17], [6'd20:6'd23], [6'd40:6'd63]}));

endmodule

// File: rtl/fsl_shadow_ram.sv
module fsl_shadow_ram
  import fsl_pkg::*;
#(
  parameter int unsigned DW  = WORD_W,
  parameter int unsigned SAW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STEP_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [SAW-1:0]    rd_idx,
  output logic [DW-1:0]     rd_data
);

  logic [DW-1:0]       mem [N_SHADOW];
  logic [N_SHADOW-1:0] vld;
  logic                in_range;
  logic [STEP_W-1:0]   rd_sel;
  logic [DW-1:0]       mem_q;
  logic                hit_q;

  assign in_range = (32'(rd_idx) < N_SHADOW);
  assign rd_sel   = in_range ? STEP_W'(rd_idx) : '0;

  // Plain write port and registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    mem_q <= mem[rd_sel];
  end

  // Loaded flags give the cleared-at-reset view without wiping the RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      hit_q <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      hit_q <= in_range && vld[rd_sel];
    end
  end

  assign rd_data = hit_q ? mem_q : '0;

  // R10: indices past the map read zero
  a_r10_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_idx) >= N_SHADOW) |=> (rd_data == '0));

endmodule

// File: rtl/fsl_status.sv
module fsl_status #(
  parameter int unsigned NTB      = 3,
  parameter int unsigned SW       = 8,
  parameter int unsigned DONE_BIT = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NTB-1:0] tbit_chk,
  input  logic           load_start,
  input  logic           load_finish,
  output logic [SW-1:0]  status
);

  logic [NTB-1:0] tb_q;
  logic           done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q   <= '0;
      done_q <= 1'b0;
    end else begin
      tb_q <= tbit_chk;
      if (load_start)       done_q <= 1'b0;
      else if (load_finish) done_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (i < NTB) begin : g_tb
      assign status[i] = tb_q[i];
    end else if (i == DONE_BIT) begin : g_done
      assign status[i] = done_q;
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end

  // R9: test-bit results appear one cycle later
  a_r9_tbit_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status[NTB-1:0] == $past(tbit_chk)));

  // R7: a starting load drops the done flag
  a_r7_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    load_start |=> !status[DONE_BIT]);

  // R2: done rises only when the last row has been written
  a_r2_done_on_finish: assert property (@(posedge clk) disable iff (rst)
    $rose(status[DONE_BIT]) |-> $past(load_finish));

endmodule

// File: rtl/fuse_shadow_loader.sv
module fuse_shadow_loader
  import fsl_pkg::*;
#(
  parameter int unsigned DW       = WORD_W,
  parameter int unsigned SAW      = 6,
  parameter int unsigned NTB      = 3,
  parameter int unsigned SW       = 8,
  parameter int unsigned DONE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl_we,
  input  logic [DW-1:0]     cl_wdata,
  output logic              fuse_rd_en,
  output logic [ROW_AW-1:0] fuse_rd_row,
  input  logic [DW-1:0]     fuse_rd_data,
  input  logic [NTB-1:0]    tbit_chk,
  input  logic [SAW-1:0]    sh_rd_idx,
  output logic [DW-1:0]     sh_rd_data,
  output logic [SW-1:0]     status
);

  logic              load_req;
  logic              wr_en;
  logic [STEP_W-1:0] wr_idx;
  logic [DW-1:0]     wr_data;
  logic              load_start;
  logic              load_finish;
  logic              unused_wdata;

  assign load_req     = cl_we && cl_wdata[0];
  assign unused_wdata = ^cl_wdata[DW-1:1];

  fsl_sequencer #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .load_req    (load_req),
    .fuse_rd_en  (fuse_rd_en),
    .fuse_rd_row (fuse_rd_row),
    .fuse_rd_data(fuse_rd_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .load_start  (load_start),
    .load_finish (load_finish)
  );

  fsl_shadow_ram #(.DW(DW), .SAW(SAW)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (sh_rd_idx),
    .rd_data(sh_rd_data)
  );

  fsl_status #(.NTB(NTB), .SW(SW), .DONE_BIT(DONE_BIT)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .tbit_chk   (tbit_chk),
    .load_start (load_start),
    .load_finish(load_finish),
    .status     (status)
  );

endmodule

// File: tb/sim_fuse_shadow_loader.sv
module sim_fuse_shadow_loader;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cl_we = 1'b0;
  logic [31:0] cl_wdata = '0;
  logic        fuse_rd_en;
  logic [5:0]  fuse_rd_row;
  logic [31:0] fuse_rd_data = '0;
  logic [2:0]  tbit_chk = '0;
  logic [5:0]  sh_rd_idx = '0;
  logic [31:0] sh_rd_data;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  bit finished = 0;

  logic [31:0] fuse [64];

  always #(CLK_P/2) clk = ~clk;

  fuse_shadow_loader u0 (
    .clk(clk), .rst(rst), .cl_we(cl_we), .cl_wdata(cl_wdata),
    .fuse_rd_en(fuse_rd_en), .fuse_rd_row(fuse_rd_row), .fuse_rd_data(fuse_rd_data),
    .tbit_chk(tbit_chk), .sh_rd_idx(sh_rd_idx), .sh_rd_data(sh_rd_data), .status(status)
  );

  // Fuse array model: answers one cycle after the strobe
  always @(posedge clk) begin
    if (fuse_rd_en) fuse_rd_data <= fuse[fuse_rd_row];
    if (fuse_rd_en && !rst) rd_cnt = rd_cnt + 1;
  end

  // Expected shadow word from the requirements
  function automatic logic [31:0] exp_word(input int i);
    int row;
    logic [31:0] m;
    m = 32'hFFFF_FFFF;
    case (i)
      0: row = 22;
      1: begin row = 16; m = 32'h0001_FFFF; end
      2: row = 20;
      3: row = 21;
      4, 5, 6: row = i - 1;
      7: row = 17;
      8: row = 6;
      17: row = 23;
      default: begin
        if (i >= 9 && i <= 16) row = i - 1;
        else if (i >= 18 && i <= 41) row = 40 + (i - 18);
        else return 32'h0;
      end
    endcase
    return fuse[row] & m;
  endfunction

  function automatic string req_of(input int i);
    if (i == 0) return "R3";
    if (i == 1) return "R4";
    if (i <= 8) return "R5";
    if (i <= 41) return "R6";
    return "R10";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic fill_fuse(input int mode);
    for (int r = 0; r < 64; r++) fuse[r] = (mode == 1) ? 32'hFFFF_FFFF : $urandom;
  endtask

  task automatic rd(input int i, output logic [31:0] d);
    sh_rd_idx = 6'(i);
    @(negedge clk);
    d = sh_rd_data;
  endtask

  task automatic wr_load(input logic [31:0] v);
    cl_we = 1'b1;
    cl_wdata = v;
    @(negedge clk);
    cl_we = 1'b0;
    cl_wdata = '0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!status[5] && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(status[5] == 1'b1, req, 32'(status[5]), 32'h1);
  endtask

  task automatic verify_all();
    logic [31:0] d;
    for (int i = 0; i < 64; i++) begin
      rd(i, d);
      check(d == exp_word(i), req_of(i), d, exp_word(i));
    end
  endtask

  // Watchdog
  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c0;
    int dly;
    void'($urandom(32'h5EED_1234));
    fill_fuse(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(status == 8'h00, "R1", 32'(status), 32'h0);
    rd(0, d);
    check(d == 32'h0, "R1", d, 32'h0);
    rst = 1'b0;
    rd(0, d);
    check(d == 32'h0, "R1", d, 32'h0);
    check(status[5] == 1'b0, "R1", 32'(status[5]), 32'h0);

    // R2: boot load reads 42 rows then sets done
    wait_done("R2");
    check(rd_cnt == 42, "R2", 32'(rd_cnt), 32'd42);
    verify_all();

    // R9: test-bit mirror, directed and random
    for (int k = 0; k < 10; k++) begin
      logic [2:0] v;
      v = (k < 8) ? 3'(k) : 3'($urandom);
      tbit_chk = v;
      @(negedge clk);
      check(status[2:0] == v, "R9", 32'(status[2:0]), 32'(v));
      check({status[7:6], status[4:3]} == 4'h0, "R9", 32'(status), 32'(status & 8'h27));
    end
    tbit_chk = '0;

    // R7: bit 0 clear has no effect
    c0 = rd_cnt;
    wr_load(32'hFFFF_FFFE);
    repeat (6) @(negedge clk);
    check(status[5] == 1'b1, "R7", 32'(status[5]), 32'h1);
    check(rd_cnt == c0, "R7", 32'(rd_cnt - c0), 32'h0);

    // R7 and R4: reload with all-ones fuses, done drops at once
    fill_fuse(1);
    c0 = rd_cnt;
    wr_load(32'h0000_0001);
    check(status[5] == 1'b0, "R7", 32'(status[5]), 32'h0);
    wait_done("R7");
    check(rd_cnt - c0 == 42, "R7", 32'(rd_cnt - c0), 32'd42);
    verify_all();

    // R8: restart mid-load with new contents, random points
    for (int it = 0; it < 6; it++) begin
      fill_fuse(0);
      wr_load(32'h0000_0001);
      dly = (it == 0) ? 0 : (it == 1) ? 1 : int'($urandom_range(2, 80));
      repeat (dly) @(negedge clk);
      fill_fuse(0);
      wr_load(32'h0000_0001);
      repeat (10) @(negedge clk);
      check(status[5] == 1'b0, "R8", 32'(status[5]), 32'h0);
      wait_done("R8");
      verify_all();
    end

    // R10: random reads including out of range
    for (int k = 0; k < 40; k++) begin
      int i;
      i = int'($urandom_range(0, 63));
      rd(i, d);
      check(d == exp_word(i), req_of(i), d, exp_word(i));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule